// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU with Status Flags

This block is the arithmetic core of a small 8-bit accumulator machine. It holds the accumulator and four status flags: carry, auxiliary (nibble) carry, signed overflow and parity. Each cycle in which `op_valid` is high, it applies one operation to them. The operation is selected by `op_code`. It may use the byte on `operand` and, for the single-bit carry group, the level on `bit_in`.

Results are computed in one combinational pass. The accumulator and the flags update on the next rising clock edge. Instruction decode, operand fetch, multiply and divide belong to the surrounding machine. That machine loads the accumulator by clearing it and adding a byte.

Reset is asynchronous and active low. Its release is synchronised inside the block, so the first operation accepted is the one presented on the third rising edge after `rst_n` goes high.

Top module: `acc_alu`

## Requirements
- R1: While reset is held, and until an operation is accepted, the accumulator reads 0x00 and carry, auxiliary carry, overflow and parity all read 0.
- R2: ADD (code 1) loads accumulator + operand; ADDC (code 2) loads accumulator + operand + carry; both set carry to the carry out of bit 7.
- R3: ADD, ADDC and SUBB set auxiliary carry to the carry out of bit 3, which for SUBB is the borrow out of bit 3.
- R4: ADD, ADDC and SUBB set overflow exactly when the signed two's-complement result falls outside -128..127.
- R5: SUBB (code 3) loads accumulator − operand − carry and sets carry when a borrow leaves bit 7.
- R6: Parity always equals the XOR of the eight accumulator bits.
- R7: INC (4) and DEC (5) wrap modulo 256. AND (6), OR (7) and XOR (8) combine the accumulator with the operand. CLRA (9) loads 0x00 and CPLA (10) inverts the accumulator. None of these changes carry, auxiliary carry or overflow.
- R8: RL (11) and RR (13) rotate the accumulator one place left or right and keep carry. RLC (12) shifts bit 7 into carry and the old carry into bit 0. RRC (14) shifts bit 0 into carry and the old carry into bit 7.
- R9: SWAP (15) exchanges bits 7:4 with bits 3:0 and leaves all flags except parity unchanged.
- R10: DA (16) first adds 0x06 when the low nibble exceeds 9 or auxiliary carry is set. It then adds 0x60 when the resulting high nibble exceeds 9 or carry is set. A carry out of either addition sets carry, carry is never cleared by DA, and auxiliary carry and overflow are kept.
- R11: CLRC (17), SETC (18) and CPLC (19) clear, set or invert carry. ANLC (20) and ORLC (22) AND or OR carry with `bit_in`; ANLCN (21) and ORLCN (23) use the inverse of `bit_in`. The accumulator and the other flags are kept.
- R12: When `op_valid` is low, or `op_code` is 0 or 24..31, the accumulator and all flags keep their values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Accept the operation this cycle |
| op_code | input | 5 | Operation select |
| operand | input | 8 | Second operand byte |
| bit_in | input | 1 | Bit operand for carry operations |
| acc | output | 8 | Accumulator |
| cy | output | 1 | Carry flag |
| ac | output | 1 | Auxiliary carry flag |
| ov | output | 1 | Overflow flag |
| par | output | 1 | Parity flag |

## Verification
The bench pushes sums across 0x7F/0x80 and 0xFF/0x00, so a design that took overflow from carry alone, or dropped the carry-in on ADDC or SUBB, would report wrong flags on these sums. Nibble-boundary sums and decimal adjusts with auxiliary carry or carry already set, and with a first step that itself carries out, catch a DA that clears carry or skips an adjustment step. Rotates-through-carry are mixed with plain rotates, which exposes a rotate that disturbs or ignores carry. A long pseudo-random stream with idle cycles shows whether an idle cycle or a reserved code changes state.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam int DW = 8;
  localparam int NW = 4;
  localparam int OPW = 5;

  typedef enum logic [OPW-1:0] {
    OP_NOP   = 5'd0,  OP_ADD   = 5'd1,  OP_ADDC  = 5'd2,  OP_SUBB  = 5'd3,
    OP_INC   = 5'd4,  OP_DEC   = 5'd5,  OP_AND   = 5'd6,  OP_OR    = 5'd7,
    OP_XOR   = 5'd8,  OP_CLRA  = 5'd9,  OP_CPLA  = 5'd10, OP_RL    = 5'd11,
    OP_RLC   = 5'd12, OP_RR    = 5'd13, OP_RRC   = 5'd14, OP_SWAP  = 5'd15,
    OP_DA    = 5'd16, OP_CLRC  = 5'd17, OP_SETC  = 5'd18, OP_CPLC  = 5'd19,
    OP_ANLC  = 5'd20, OP_ANLCN = 5'd21, OP_ORLC  = 5'd22, OP_ORLCN = 5'd23
  } alu_op_e;

  typedef struct packed {
    logic cy;
    logic ac;
    logic ov;
  } alu_flags_t;
endpackage

// File: rtl/alu_arith.sv
module alu_arith #(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         sub,
  output logic [W-1:0] sum,
  output logic         cy_out,
  output logic         aux_out,
  output logic         ovf
);
  localparam int MIDW = W - 1 - NIB;

  logic [W-1:0]  b_eff;
  logic          c_eff;
  logic [NIB:0]  lo_sum;
  logic [MIDW:0] mid_sum;
  logic [1:0]    top_sum;

  // subtraction is a + ~b + ~borrow_in; carries become inverted borrows
  always_comb begin
    b_eff   = sub ? ~b : b;
    c_eff   = sub ? ~cin : cin;
    lo_sum  = {1'b0, a[NIB-1:0]} + {1'b0, b_eff[NIB-1:0]} + {{NIB{1'b0}}, c_eff};
    mid_sum = {1'b0, a[W-2:NIB]} + {1'b0, b_eff[W-2:NIB]} + {{MIDW{1'b0}}, lo_sum[NIB]};
    top_sum = {1'b0, a[W-1]} + {1'b0, b_eff[W-1]} + {1'b0, mid_sum[MIDW]};
    sum     = {top_sum[0], mid_sum[MIDW-1:0], lo_sum[NIB-1:0]};
    cy_out  = top_sum[1] ^ sub;
    aux_out = lo_sum[NIB] ^ sub;
    ovf     = mid_sum[MIDW] ^ top_sum[1];
  end
endmodule

// File: rtl/alu_byteops.sv
module alu_byteops
  import alu_pkg::*;
#(
  parameter int W   = 8,
  parameter int NIB = 4
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  input  logic         acin,
  output logic [W-1:0] res,
  output logic         cy_out,
  output logic         cy_we
);
  localparam logic [NIB-1:0] DEC_MAX = NIB'(9);
  localparam logic [W:0]     ADJ_LO  = (W+1)'(6);
  localparam logic [W:0]     ADJ_HI  = (W+1)'(6) << NIB;

  logic [W:0] da_s1, da_s2;
  logic       da_c1, da_lo, da_hi;

  // two-step decimal correction, carry accumulates across both steps
  always_comb begin
    da_lo = (a[NIB-1:0] > DEC_MAX) || acin;
    da_s1 = {1'b0, a} + (da_lo ? ADJ_LO : '0);
    da_c1 = cin | da_s1[W];
    da_hi = (da_s1[W-1:W-NIB] > DEC_MAX) || da_c1;
    da_s2 = {1'b0, da_s1[W-1:0]} + (da_hi ? ADJ_HI : '0);
  end

  always_comb begin
    res    = a;
    cy_out = cin;
    cy_we  = 1'b0;
    unique case (op)
      OP_INC:  res = a + W'(1);
      OP_DEC:  res = a - W'(1);
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      OP_CLRA: res = '0;
      OP_CPLA: res = ~a;
      OP_RL:   res = {a[W-2:0], a[W-1]};
      OP_RR:   res = {a[0], a[W-1:1]};
      OP_RLC: begin
        res    = {a[W-2:0], cin};
        cy_out = a[W-1];
        cy_we  = 1'b1;
      end
      OP_RRC: begin
        res    = {cin, a[W-1:1]};
        cy_out = a[0];
        cy_we  = 1'b1;
      end
      OP_SWAP: res = {a[NIB-1:0], a[W-1:NIB]};
      OP_DA: begin
        res    = da_s2[W-1:0];
        cy_out = da_c1 | da_s2[W];
        cy_we  = 1'b1;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/alu_carry_bit.sv
module alu_carry_bit
  import alu_pkg::*;
(
  input  alu_op_e op,
  input  logic    cin,
  input  logic    bit_in,
  output logic    cy_out
);
  always_comb begin
    unique case (op)
      OP_CLRC:  cy_out = 1'b0;
      OP_SETC:  cy_out = 1'b1;
      OP_CPLC:  cy_out = ~cin;
      OP_ANLC:  cy_out = cin & bit_in;
      OP_ANLCN: cy_out = cin & ~bit_in;
      OP_ORLC:  cy_out = cin | bit_in;
      OP_ORLCN: cy_out = cin | ~bit_in;
      default:  cy_out = cin;
    endcase
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import alu_pkg::*;
#(
  parameter int W   = DW,
  parameter int NIB = NW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   operand,
  input  logic           bit_in,
  output logic [W-1:0]   acc,
  output logic           cy,
  output logic           ac,
  output logic           ov,
  output logic           par
);
  // reset synchroniser: assert asynchronously, release on the clock
  logic rst_meta, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta   <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta   <= 1'b1;
      rst_sync_n <= rst_meta;
    end
  end

  alu_op_e    op;
  logic [W-1:0] acc_q, acc_d;
  alu_flags_t fl_q, fl_d;
  logic       par_q, par_d;

  logic [W-1:0] ar_sum, bo_res;
  logic ar_cy, ar_aux, ar_ovf, ar_sub, ar_cin;
  logic bo_cy, bo_we, cb_cy;

  assign op     = alu_op_e'(op_code);
  assign ar_sub = (op == OP_SUBB);
  assign ar_cin = (op == OP_ADD) ? 1'b0 : fl_q.cy;

  alu_arith #(.W(W), .NIB(NIB)) u_arith (
    .a(acc_q), .b(operand), .cin(ar_cin), .sub(ar_sub),
    .sum(ar_sum), .cy_out(ar_cy), .aux_out(ar_aux), .ovf(ar_ovf)
  );

  alu_byteops #(.W(W), .NIB(NIB)) u_byteops (
    .op(op), .a(acc_q), .b(operand), .cin(fl_q.cy), .acin(fl_q.ac),
    .res(bo_res), .cy_out(bo_cy), .cy_we(bo_we)
  );

  alu_carry_bit u_cbit (
    .op(op), .cin(fl_q.cy), .bit_in(bit_in), .cy_out(cb_cy)
  );

  // next-state selection
  always_comb begin
    acc_d = acc_q;
    fl_d  = fl_q;
    unique case (op)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        acc_d = ar_sum;
        fl_d  = '{cy: ar_cy, ac: ar_aux, ov: ar_ovf};
      end
      OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CLRA, OP_CPLA,
      OP_RL, OP_RLC, OP_RR, OP_RRC, OP_SWAP, OP_DA: begin
        acc_d = bo_res;
        if (bo_we) fl_d.cy = bo_cy;
      end
      OP_CLRC, OP_SETC, OP_CPLC, OP_ANLC, OP_ANLCN, OP_ORLC, OP_ORLCN:
        fl_d.cy = cb_cy;
      default: ;
    endcase
    par_d = ^acc_d;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      acc_q <= '0;
      fl_q  <= '0;
      par_q <= 1'b0;
    end else if (op_valid) begin
      acc_q <= acc_d;
      fl_q  <= fl_d;
      par_q <= par_d;
    end
  end

  assign acc = acc_q;
  assign cy  = fl_q.cy;
  assign ac  = fl_q.ac;
  assign ov  = fl_q.ov;
  assign par = par_q;

  a_r6_parity_tracks: assert property (@(posedge clk) disable iff (!rst_sync_n)
    par == ^acc);

  a_r12_idle_holds: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !op_valid |=> $stable(acc) && $stable(cy) && $stable(ac) && $stable(ov));

  a_r7_flags_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op inside {OP_INC, OP_DEC, OP_AND, OP_OR, OP_XOR, OP_CLRA, OP_CPLA})
    |=> $stable(cy) && $stable(ac) && $stable(ov));

  a_r8_plain_rotate_carry: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op == OP_RL || op == OP_RR) |=> $stable(cy));

  a_r10_da_carry_sticky: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && op == OP_DA && cy |=> cy);

  a_r11_bitop_acc_kept: assert property (@(posedge clk) disable iff (!rst_sync_n)
    op_valid && (op inside {OP_CLRC, OP_SETC, OP_CPLC, OP_ANLC, OP_ANLCN, OP_ORLC, OP_ORLCN})
    |=> $stable(acc) && $stable(ac) && $stable(ov));
endmodule

// File: tb/tb_acc_alu.sv
module tb_acc_alu;
  import alu_pkg::*;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [4:0] op_code = '0;
  logic [7:0] operand = '0;
  logic       bit_in = 1'b0;
  logic [7:0] acc;
  logic       cy, ac, ov, par;

  always #10 clk = ~clk;

  acc_alu dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .operand(operand), .bit_in(bit_in), .acc(acc), .cy(cy), .ac(ac),
    .ov(ov), .par(par)
  );

  typedef struct {
    logic [7:0] acc;
    logic cy, ac, ov, par;
    string tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  int m_acc = 0, m_cy = 0, m_ac = 0, m_ov = 0;

  function automatic int sgn(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  function automatic int parity(int v);
    int p = 0;
    for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
    return p;
  endfunction

  function automatic string tag_of(bit v, int op);
    if (!v || op == 0 || op > 23) return "R12 R6";
    case (op)
      1, 2:   return "R2 R3 R4 R6";
      3:      return "R5 R3 R4 R6";
      11,12,13,14: return "R8 R6";
      15:     return "R9 R6";
      16:     return "R10 R6";
      default: return (op >= 17) ? "R11 R6" : "R7 R6";
    endcase
  endfunction

  // reference model written from the requirements in integer arithmetic
  task automatic model(int op, int b, int bi);
    int r, s;
    case (op)
      1, 2: begin
        int c = (op == 2) ? m_cy : 0;
        r = m_acc + b + c;
        m_ac = (((m_acc & 15) + (b & 15) + c) > 15);
        s = sgn(m_acc) + sgn(b) + c;
        m_ov = (s > 127 || s < -128);
        m_cy = (r > 255);
        m_acc = r & 255;
      end
      3: begin
        r = m_acc - b - m_cy;
        m_ac = (((m_acc & 15) - (b & 15) - m_cy) < 0);
        s = sgn(m_acc) - sgn(b) - m_cy;
        m_ov = (s > 127 || s < -128);
        m_cy = (r < 0);
        m_acc = r & 255;
      end
      4:  m_acc = (m_acc + 1) & 255;
      5:  m_acc = (m_acc + 255) & 255;
      6:  m_acc = m_acc & b;
      7:  m_acc = m_acc | b;
      8:  m_acc = m_acc ^ b;
      9:  m_acc = 0;
      10: m_acc = (~m_acc) & 255;
      11: m_acc = ((m_acc << 1) | (m_acc >> 7)) & 255;
      12: begin r = (m_acc >> 7) & 1; m_acc = ((m_acc << 1) | m_cy) & 255; m_cy = r; end
      13: m_acc = ((m_acc >> 1) | (m_acc << 7)) & 255;
      14: begin r = m_acc & 1; m_acc = (m_acc >> 1) | (m_cy << 7); m_cy = r; end
      15: m_acc = ((m_acc << 4) | (m_acc >> 4)) & 255;
      16: begin
        if ((m_acc & 15) > 9 || m_ac) begin
          r = m_acc + 6; if (r > 255) m_cy = 1; m_acc = r & 255;
        end
        if ((m_acc >> 4) > 9 || m_cy) begin
          r = m_acc + 96; if (r > 255) m_cy = 1; m_acc = r & 255;
        end
      end
      17: m_cy = 0;
      18: m_cy = 1;
      19: m_cy = 1 - m_cy;
      20: m_cy = m_cy & bi;
      21: m_cy = m_cy & (1 - bi);
      22: m_cy = m_cy | bi;
      23: m_cy = m_cy | (1 - bi);
      default: ;
    endcase
  endtask

  // driver: one operation per call, expectation goes to the scoreboard
  task automatic drive(bit v, int op, int b, int bi = 0);
    exp_t e;
    @(negedge clk);
    op_valid = v;
    op_code  = 5'(op);
    operand  = 8'(b);
    bit_in   = 1'(bi);
    if (v) model(op, b, bi);
    e.acc = 8'(m_acc); e.cy = 1'(m_cy); e.ac = 1'(m_ac); e.ov = 1'(m_ov);
    e.par = 1'(parity(m_acc)); e.tag = tag_of(v, op);
    exp_q.push_back(e);
  endtask

  task automatic load(int v);
    drive(1, 17, 0); drive(1, 9, 0); drive(1, 1, v);
  endtask

  // monitor: compares mid-cycle after the edge that captured the operation
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0 && !done) begin
      exp_t e;
      e = exp_q.pop_front();
      n_chk++;
      if ({acc, cy, ac, ov, par} !== {e.acc, e.cy, e.ac, e.ov, e.par}) begin
        n_bad++;
        $display("FAIL %s: acc=%02h cy=%0b ac=%0b ov=%0b p=%0b expected acc=%02h cy=%0b ac=%0b ov=%0b p=%0b",
                 e.tag, acc, cy, ac, ov, par, e.acc, e.cy, e.ac, e.ov, e.par);
      end
    end
  end

  initial begin
    #200_000_000;
    if (!done) begin
      done = 1;
      n_bad++;
      $display("FAIL watchdog: acc=%02h expected completion", acc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    bit [15:0] lf = 16'hACE1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1: reset state before any operation
    n_chk++;
    if ({acc, cy, ac, ov, par} !== 12'h0) begin
      n_bad++;
      $display("FAIL R1: acc=%02h flags=%0b%0b%0b%0b expected 00 0000", acc, cy, ac, ov, par);
    end

    // R2 R3 R4 R5: signed and unsigned boundaries
    load(8'h7F); drive(1, 1, 8'h01);
    drive(1, 1, 8'h80);
    drive(1, 2, 8'h0F);
    drive(1, 18, 0); drive(1, 2, 8'hFF);
    load(8'h10); drive(1, 3, 8'h20);
    drive(1, 3, 8'h01);
    load(8'h80); drive(1, 3, 8'h01);
    load(8'h00); drive(1, 18, 0); drive(1, 3, 8'h00);
    // R7: wraps and logic keep flags
    load(8'hFF); drive(1, 4, 0); drive(1, 5, 0); drive(1, 5, 0);
    drive(1, 6, 8'h3C); drive(1, 7, 8'h81); drive(1, 8, 8'hFF);
    drive(1, 10, 0); drive(1, 9, 0);
    // R8 R9: rotates and swap
    load(8'hA5); drive(1, 18, 0);
    drive(1, 11, 0); drive(1, 13, 0); drive(1, 12, 0); drive(1, 12, 0);
    drive(1, 14, 0); drive(1, 14, 0); drive(1, 15, 0);
    // R10: decimal adjust cases
    load(8'h38); drive(1, 1, 8'h45); drive(1, 16, 0);
    load(8'h99); drive(1, 1, 8'h99); drive(1, 16, 0);
    load(8'h09); drive(1, 1, 8'h09); drive(1, 16, 0);
    load(8'hFA); drive(1, 16, 0);
    load(8'h12); drive(1, 18, 0); drive(1, 16, 0);
    // R11: bit operations with both bit levels
    for (int bi = 0; bi < 2; bi++)
      for (int op = 17; op <= 23; op++) begin
        drive(1, 18, 0); drive(1, op, 0, bi);
        drive(1, 17, 0); drive(1, op, 0, bi);
      end
    // R12: idle cycles and reserved codes
    load(8'h5A); drive(0, 1, 8'h33); drive(1, 0, 8'h33);
    drive(1, 27, 8'h33); drive(0, 16, 0);
    // mixed pseudo-random stream
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      drive(lf[15:12] != 4'h0, int'(lf[10:6]) % 24, int'(lf[7:0] ^ lf[15:8]), int'(lf[3]));
    end
    drive(0, 0, 0);
    repeat (3) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule